// File: doc/BRIEF.md
# Data Object Mailbox Responder

This block is the device side of a data object mailbox. It sits on a simple 32-bit register bus and has four word registers: control, status, write mailbox and read mailbox. The host writes a request object one dword at a time into the write mailbox. It then sets the go bit in the control register. The block checks the buffered object and, if the object is valid, passes it to a built-in handler. That handler answers only the discovery protocol, using a protocol table fixed by parameters. The response is streamed back through the read mailbox.

The read mailbox is pull-with-acknowledge. A read returns the current response dword and does not consume it. A write of any value to the read mailbox moves on to the next dword.

A malformed or unsupported request raises the error flag and produces no response. The host recovers by writing the abort bit, which returns the mailbox to an empty idle state.

Top module: `objx_mailbox`

## Requirements
- R1: After reset the status register (word 1) reads zero and the read mailbox (word 3) reads zero. The control register (word 0) always reads zero.
- R2: Register map by word address: 0 = control (bit 0 abort, bit 1 go), 1 = status (bit 0 busy, bit 1 error, bit 2 object ready, other bits zero), 2 = write mailbox, 3 = read mailbox. Status reads zero in the busy, ready and error flags when idle.
- R3: A go write accepted in the idle state makes busy read 1 in the following cycle. Busy then lasts exactly one cycle, after which either ready or error is set.
- R4: A valid discovery request is answered with three dwords. Dword 0 is header 1: the discovery vendor identifier (default 16'h0001) in bits 15:0, type 0 in bits 23:16, and bits 31:24 zero. Dword 1 is header 2: length 3 in bits 17:0. Dword 2 is the table entry selected by the request index: vendor in bits 15:0, type in bits 23:16 and the next index in bits 31:24. The next index is 0 for the last table entry. The request payload carries the index in bits 7:0. The default table is index 0 = vendor 16'h0001 type 8'h00, index 1 = vendor 16'h1AB5 type 8'h02, and index 2 = vendor 16'h3C4D type 8'h07.
- R5: Reading the read mailbox does not advance it. Each write to the read mailbox advances one dword. Ready stays set until the third dword is acknowledged, then clears, and the read mailbox then reads zero.
- R6: The request's length field counts the two header dwords plus the payload. If this length differs from the number of dwords actually written, go sets error and no response is produced. A length field of zero means 2^18 dwords, so it always mismatches a buffered request.
- R7: If header 1 does not carry the discovery vendor identifier in bits 15:0 and type 0 in bits 23:16, go sets error.
- R8: A request of more than REQ_DEPTH (default 16) dwords sets error at go.
- R9: A discovery index at or beyond the table size sets error at go.
- R10: A control write with the abort bit discards any buffered request and any pending response, and clears busy, error and ready. If abort and go are set in the same write, abort wins and go is dropped.
- R11: Writes to the write mailbox are ignored unless the mailbox is idle, that is, while busy, ready or in error.
- R12: A go write is ignored while a response is pending. Ready stays set and the current read dword is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr | input | 2 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational and free of side effects |

## Verification
Abort and go are both carried in the control register, so a single write can request both at once. The bench writes both bits together after buffering a complete valid request. It then expects idle status immediately. A plain go issued afterwards must end in error, because the discarded buffer no longer matches its stale length field. A second collision puts a write-mailbox write into the one-cycle busy window right after go. The bench judges it ignored because a following well-formed request of exactly three dwords still gets a correct answer.

// File: rtl/objx_pkg.sv
package objx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUSY,
        ST_RESP,
        ST_FAULT
    } mb_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_WMB  = 2'd2;
    localparam logic [1:0] ADDR_RMB  = 2'd3;

    localparam int CTL_ABORT = 0;
    localparam int CTL_GO    = 1;

    localparam int LEN_W     = 18;
    localparam int RSP_WORDS = 3;

endpackage

// File: rtl/objx_reqbuf.sv
module objx_reqbuf #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          clear,
    input  logic [31:0]   wdata,
    output logic [31:0]   hdr1,
    output logic [31:0]   hdr2,
    output logic [31:0]   pay0,
    output logic [CW-1:0] count,
    output logic          ovf
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ovf;
    } buf_state_t;

    buf_state_t s_d, s_q;
    logic [31:0] mem_q [DEPTH];
    logic        room;

    assign room = (s_q.cnt < CW'(DEPTH));

    always_comb begin
        s_d = s_q;
        if (clear) begin
            s_d = '0;
        end else if (push) begin
            if (room) s_d.cnt = s_q.cnt + 1'b1;
            else      s_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push && !clear && room) mem_q[s_q.cnt[IW-1:0]] <= wdata;
    end

    assign hdr1  = mem_q[0];
    assign hdr2  = mem_q[1];
    assign pay0  = mem_q[2];
    assign count = s_q.cnt;
    assign ovf   = s_q.ovf;

    // R8
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clear && count == CW'(DEPTH)) |=> ovf);

    // R8
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clear) |=> ovf);

endmodule

// File: rtl/objx_disc_handler.sv
module objx_disc_handler #(
    parameter int                        DEPTH    = 16,
    parameter int                        TABLE_N  = 3,
    parameter logic [15:0]               DISC_VID = 16'h0001,
    parameter logic [TABLE_N-1:0][23:0]  PROTOS   = {24'h073C4D, 24'h021AB5, 24'h000001},
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [31:0]   hdr1,
    input  logic [31:0]   hdr2,
    input  logic [31:0]   pay0,
    input  logic [CW-1:0] count,
    input  logic          ovf,
    output logic          accept,
    output logic [31:0]   payload
);
    import objx_pkg::*;

    logic [LEN_W:0] len_eff;
    logic [7:0]     idx;
    logic [7:0]     nxt;
    logic [23:0]    entry;
    logic           in_range, hdr_ok, len_ok;
    logic           unused_bits;

    assign unused_bits = ^{hdr1[31:24], hdr2[31:LEN_W], pay0[31:8]};

    assign len_eff  = (hdr2[LEN_W-1:0] == '0) ? (LEN_W+1)'(1) << LEN_W
                                               : {1'b0, hdr2[LEN_W-1:0]};
    assign idx      = pay0[7:0];
    assign in_range = (idx < 8'(TABLE_N));
    assign hdr_ok   = (hdr1[15:0] == DISC_VID) && (hdr1[23:16] == 8'h00);
    assign len_ok   = (len_eff == (LEN_W+1)'(count)) && (count == CW'(RSP_WORDS));

    always_comb begin
        entry = '0;
        for (int i = 0; i < TABLE_N; i++) begin
            if (idx == 8'(i)) entry = PROTOS[i];
        end
    end

    assign nxt     = (idx == 8'(TABLE_N - 1)) ? 8'h00 : idx + 8'h01;
    assign accept  = !ovf && hdr_ok && len_ok && in_range;
    assign payload = {nxt, entry};

endmodule

// File: rtl/objx_mailbox.sv
module objx_mailbox #(
    parameter int                        REQ_DEPTH = 16,
    parameter int                        TABLE_N   = 3,
    parameter logic [15:0]               DISC_VID  = 16'h0001,
    parameter logic [TABLE_N-1:0][23:0]  PROTOS    = {24'h073C4D, 24'h021AB5, 24'h000001}
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    import objx_pkg::*;

    localparam int CW = $clog2(REQ_DEPTH + 1);

    typedef struct packed {
        mb_state_e   st;
        logic [1:0]  ptr;
        logic [31:0] pay;
    } mb_t;

    mb_t s_d, s_q;

    logic          ctrl_wr, abort_req, go_req, push, pop, buf_clear;
    logic [31:0]   hdr1, hdr2, pay0, rsp_word, h_payload;
    logic [CW-1:0] count;
    logic          ovf, h_accept;

    assign ctrl_wr   = reg_wr && (reg_addr == ADDR_CTRL);
    assign abort_req = ctrl_wr && reg_wdata[CTL_ABORT];
    assign go_req    = ctrl_wr && reg_wdata[CTL_GO] && !reg_wdata[CTL_ABORT];
    assign push      = reg_wr && (reg_addr == ADDR_WMB) && (s_q.st == ST_IDLE);
    assign pop       = reg_wr && (reg_addr == ADDR_RMB) && (s_q.st == ST_RESP);
    assign buf_clear = abort_req || (s_q.st == ST_BUSY);

    objx_reqbuf #(.DEPTH(REQ_DEPTH)) i_reqbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .clear (buf_clear),
        .wdata (reg_wdata),
        .hdr1  (hdr1),
        .hdr2  (hdr2),
        .pay0  (pay0),
        .count (count),
        .ovf   (ovf)
    );

    objx_disc_handler #(
        .DEPTH    (REQ_DEPTH),
        .TABLE_N  (TABLE_N),
        .DISC_VID (DISC_VID),
        .PROTOS   (PROTOS)
    ) i_handler (
        .hdr1    (hdr1),
        .hdr2    (hdr2),
        .pay0    (pay0),
        .count   (count),
        .ovf     (ovf),
        .accept  (h_accept),
        .payload (h_payload)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: if (go_req) s_d.st = ST_BUSY;
            ST_BUSY: begin
                if (h_accept) begin
                    s_d.st  = ST_RESP;
                    s_d.ptr = 2'd0;
                    s_d.pay = h_payload;
                end else begin
                    s_d.st  = ST_FAULT;
                end
            end
            ST_RESP: begin
                if (pop) begin
                    if (s_q.ptr == 2'(RSP_WORDS - 1)) begin
                        s_d.st  = ST_IDLE;
                        s_d.ptr = 2'd0;
                        s_d.pay = '0;
                    end else begin
                        s_d.ptr = s_q.ptr + 2'd1;
                    end
                end
            end
            default: ;
        endcase
        if (abort_req) s_d = '{st: ST_IDLE, ptr: 2'd0, pay: 32'h0};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, ptr: 2'd0, pay: 32'h0};
        else        s_q <= s_d;
    end

    always_comb begin
        unique case (s_q.ptr)
            2'd0:    rsp_word = {8'h00, 8'h00, DISC_VID};
            2'd1:    rsp_word = 32'(RSP_WORDS);
            default: rsp_word = s_q.pay;
        endcase
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_STAT: reg_rdata = {29'h0, s_q.st == ST_RESP, s_q.st == ST_FAULT,
                                    s_q.st == ST_BUSY};
            ADDR_RMB:  reg_rdata = (s_q.st == ST_RESP) ? rsp_word : 32'h0;
            default:   reg_rdata = '0;
        endcase
    end

    // R3
    go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_CTRL && reg_wdata[1:0] == 2'b10 && s_q.st == ST_IDLE)
        |=> s_q.st == ST_BUSY);

    // R3
    busy_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_BUSY) |=> (s_q.st == ST_RESP || s_q.st == ST_FAULT));

    // R10
    abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_CTRL && reg_wdata[0])
        |=> (s_q.st == ST_IDLE && count == '0 && !ovf));

    // R5
    last_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_RESP && reg_wr && reg_addr == ADDR_RMB && s_q.ptr == 2'd2)
        |=> s_q.st == ST_IDLE);

    // R11
    wmb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_WMB && s_q.st != ST_IDLE && s_q.st != ST_BUSY)
        |=> $stable(count));

    // R12
    go_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_RESP && reg_wr && reg_addr == ADDR_CTRL && reg_wdata[1:0] == 2'b10)
        |=> (s_q.st == ST_RESP && $stable(s_q.ptr) && $stable(s_q.pay)));

endmodule

// File: tb/test_objx_mailbox.sv
module test_objx_mailbox;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    objx_mailbox i_objx_mailbox (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    typedef struct packed {
        logic [15:0] vid;
        logic [7:0]  typ;
        logic [17:0] len;
        logic [7:0]  idx;
        logic        ok;
        logic [31:0] pay;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{16'h0001, 8'h00, 18'd3, 8'd0, 1'b1, 32'h01000001, 4'd4},
        '{16'h0001, 8'h00, 18'd3, 8'd1, 1'b1, 32'h02021AB5, 4'd4},
        '{16'h0001, 8'h00, 18'd3, 8'd2, 1'b1, 32'h00073C4D, 4'd4},
        '{16'h0001, 8'h00, 18'd3, 8'd3, 1'b0, 32'h0,        4'd9},
        '{16'h0002, 8'h00, 18'd3, 8'd0, 1'b0, 32'h0,        4'd7},
        '{16'h0001, 8'h01, 18'd3, 8'd0, 1'b0, 32'h0,        4'd7},
        '{16'h0001, 8'h00, 18'd4, 8'd0, 1'b0, 32'h0,        4'd6},
        '{16'h0001, 8'h00, 18'd0, 8'd0, 1'b0, 32'h0,        4'd6}
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic send_req(input logic [15:0] vid, input logic [7:0] typ,
                            input logic [17:0] len, input logic [7:0] idx);
        wr(2'd2, {8'h00, typ, vid});
        wr(2'd2, {14'h0, len});
        wr(2'd2, {24'h0, idx});
    endtask

    task automatic drain_ok(input logic [31:0] pay, input string tag);
        logic [31:0] v;
        rd(2'd1, v);  chk(v, 32'h4, {tag, " ready status"});
        rd(2'd3, v);  chk(v, 32'h00000001, {tag, " R4 header1"});
        rd(2'd3, v);  chk(v, 32'h00000001, {tag, " R5 peek repeat"});
        wr(2'd3, 32'h0);
        rd(2'd3, v);  chk(v, 32'h00000003, {tag, " R4 header2"});
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, v);  chk(v, pay, {tag, " R4 payload"});
        wr(2'd3, 32'h1234);
        rd(2'd1, v);  chk(v, 32'h0, {tag, " R5 ready cleared"});
        rd(2'd3, v);  chk(v, 32'h0, {tag, " R5 rmb zero"});
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0;
        reg_wr = 1'b0;
        reg_addr = 2'd0;
        reg_wdata = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R2: reset state
        rd(2'd1, v);  chk(v, 32'h0, "R1 status after reset");
        rd(2'd3, v);  chk(v, 32'h0, "R1 rmb after reset");
        @(negedge clk);
        rd(2'd0, v);  chk(v, 32'h0, "R2 control reads zero");

        // table-driven query sweep: R4 R6 R7 R9, with R3 busy timing
        for (int n = 0; n < NV; n++) begin
            @(negedge clk);
            send_req(VECS[n].vid, VECS[n].typ, VECS[n].len, VECS[n].idx);
            wr(2'd0, 32'h2);
            rd(2'd1, v);  chk(v, 32'h1, $sformatf("R3 busy after go vec%0d", n));
            @(negedge clk);
            if (VECS[n].ok) begin
                drain_ok(VECS[n].pay, $sformatf("vec%0d", n));
            end else begin
                rd(2'd1, v);
                chk(v, 32'h2, $sformatf("R%0d error vec%0d", VECS[n].req, n));
                rd(2'd3, v);  chk(v, 32'h0, $sformatf("R%0d no response vec%0d", VECS[n].req, n));
                @(negedge clk);
                wr(2'd0, 32'h1);
                rd(2'd1, v);  chk(v, 32'h0, $sformatf("R10 abort clears vec%0d", n));
            end
        end

        // R8: overflow of the request buffer
        @(negedge clk);
        wr(2'd2, 32'h00000001);
        wr(2'd2, 32'd17);
        for (int k = 0; k < 15; k++) wr(2'd2, 32'h0);
        wr(2'd0, 32'h2);
        @(negedge clk);
        rd(2'd1, v);  chk(v, 32'h2, "R8 overflow sets error");
        @(negedge clk);
        wr(2'd0, 32'h1);

        // R10: abort and go in the same write
        send_req(16'h0001, 8'h00, 18'd3, 8'd0);
        wr(2'd0, 32'h3);
        rd(2'd1, v);  chk(v, 32'h0, "R10 abort wins over go");
        @(negedge clk);
        wr(2'd0, 32'h2);
        @(negedge clk);
        rd(2'd1, v);  chk(v, 32'h2, "R10 buffer discarded by abort");
        @(negedge clk);
        wr(2'd0, 32'h1);

        // R10: abort with a pending response
        send_req(16'h0001, 8'h00, 18'd3, 8'd1);
        wr(2'd0, 32'h2);
        @(negedge clk);
        wr(2'd0, 32'h1);
        rd(2'd1, v);  chk(v, 32'h0, "R10 abort drops response");
        rd(2'd3, v);  chk(v, 32'h0, "R10 rmb zero after abort");

        // R11 / R12: stray writes while busy and while ready
        @(negedge clk);
        send_req(16'h0001, 8'h00, 18'd3, 8'd2);
        wr(2'd0, 32'h2);
        wr(2'd2, 32'hDEAD_0001);
        wr(2'd2, 32'hBEEF_0002);
        wr(2'd0, 32'h2);
        rd(2'd1, v);  chk(v, 32'h4, "R12 go ignored while ready");
        rd(2'd3, v);  chk(v, 32'h00000001, "R12 read dword unchanged");
        @(negedge clk);
        drain_ok(32'h00073C4D, "R11 first");
        @(negedge clk);
        send_req(16'h0001, 8'h00, 18'd3, 8'd1);
        wr(2'd0, 32'h2);
        @(negedge clk);
        drain_ok(32'h02021AB5, "R11 stray writes ignored");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule